// File: doc/BRIEF.md
# Boot Vector Substituting ROM Slave

A read-only bus slave that answers word reads inside a 512-byte window at octal byte addresses 773000 to 773776. Ordinary reads return words from a boot ROM. Some reads are different: when the processor fetches its power-up trap vector through the window, the slave returns a computed start address and a fixed status word in place of the ROM contents.

The start address is a fixed base (octal 173000). The 8-bit offset of the selected start line is shifted left by one and ORed into it. Four one-hot start-select lines come from a separate restart sequencer, and each line has its own offset constant. When the vector is fetched through the alternate location and no line is set, line 1 is used by default. This is how the system reloads by itself after a real power failure.

A blind input from the sequencer silences the slave entirely. An extension enable opens the upper 128 words of the window. Every response is registered and appears exactly one cycle after the request.

Top module: `boot_vector_rom`

## Requirements
- R1: A read (bus_rd=1, bus_wr=0) whose byte address bits 17:9 equal octal 773 and whose bit 8 is 0 is acknowledged in the next cycle. For addresses other than the vector slots, the data is the ROM word at index bus_addr[8:1]. Bit 0 of the address is ignored. A read outside the window gets no acknowledge.
- R2: ROM word at index i (0..255) is {i, ~i} XOR 16'hA55A, with i in bits 15:8 and its complement in bits 7:0.
- R3: Addresses with bit 8 set (773400–773776) are acknowledged only while ext_rom_en=1.
- R4: A read at byte offset 024 or 224 of the window (word index 10 or 74) returns 16'o173000 OR (offset of the selected line << 1). Line n's offset is line_offset[8n+7:8n]. Line 1 is n=0 and is selected by start_sel[0].
- R5: With no start_sel bit set, a read at offset 224 uses line 1's offset, and a read at offset 024 returns the plain 16'o173000.
- R6: A read at offset 026 or 226 (word index 11 or 75) always returns 16'o000340, in place of the ROM word.
- R7: While blind=1, no access is acknowledged.
- R8: A cycle with bus_wr=1, or with bus_rd=0, is never acknowledged.
- R9: If several start_sel bits are set together, the lowest-numbered line wins.
- R10: rsp_data is zero in every cycle where rsp_ack is 0. Reset clears rsp_ack and rsp_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 18 | Byte address of the access |
| bus_rd | input | 1 | Read request strobe |
| bus_wr | input | 1 | Write request strobe (never answered) |
| start_sel | input | 4 | One-hot start-line selection from the sequencer |
| blind | input | 1 | Suppresses every acknowledge while high |
| line_offset | input | 32 | Four 8-bit start offsets, line n in bits 8n+7:8n |
| ext_rom_en | input | 1 | Opens the upper 128 words of the window |
| rsp_data | output | 16 | Read data, zero when not acknowledged |
| rsp_ack | output | 1 | Acknowledge, one cycle after the request |

## Verification
A wrong decode or a wrong source choice shows on the very next cycle after the request. It appears as a missing or extra rsp_ack, or as a word that differs from the ROM formula, the status constant, or the base-OR-offset sum. A wrong line-priority or default choice can only show on a vector-slot read. For that reason, vector reads are made under every start_sel pattern, including none and several at once, through both the primary and the alternate slot. Blind, write and extension gating are each toggled around reads that would otherwise be answered.

// File: rtl/bvr_pkg.sv
package bvr_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ROM  = 2'd1,
    SRC_PC   = 2'd2,
    SRC_PSW  = 2'd3
  } bvr_src_e;

  // Boot ROM contents: index in the high byte, its complement low, scrambled.
  function automatic logic [15:0] rom_word(input logic [7:0] idx);
    return {idx, ~idx} ^ 16'hA55A;
  endfunction

  // Start address: base with the line offset placed over bits 8..1.
  function automatic logic [15:0] start_word(input logic [15:0] base,
                                             input logic [7:0]  off);
    return base | {7'd0, off, 1'b0};
  endfunction

endpackage

// File: rtl/bvr_decode.sv
module bvr_decode #(
  parameter int ADDR_W  = 18,
  parameter int TAG_W   = ADDR_W - 9,
  parameter logic [TAG_W-1:0] WIN_TAG = 9'o773,
  parameter logic [5:0] PC_SLOT  = 6'o12,
  parameter logic [5:0] PSW_SLOT = 6'o13
) (
  input  logic [ADDR_W-1:1] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              blind,
  input  logic              ext_en,
  output logic              access,
  output logic              pc_hit,
  output logic              psw_hit,
  output logic              alt_slot,
  output logic [7:0]        word_idx
);
  logic win_hit;
  logic upper;
  logic low_zone;

  assign win_hit  = (addr[ADDR_W-1:9] == WIN_TAG);
  assign upper    = addr[8];
  assign low_zone = !upper;
  assign word_idx = addr[8:1];
  assign alt_slot = addr[7];

  assign access  = rd && !wr && !blind && win_hit && (low_zone || ext_en);
  assign pc_hit  = access && low_zone && (addr[6:1] == PC_SLOT);
  assign psw_hit = access && low_zone && (addr[6:1] == PSW_SLOT);
endmodule

// File: rtl/bvr_linesel.sv
module bvr_linesel #(
  parameter int LINES = 4,
  parameter int OFF_W = 8
) (
  input  logic [LINES-1:0]       sel,
  input  logic [LINES*OFF_W-1:0] offsets,
  input  logic                   alt_slot,
  output logic [OFF_W-1:0]       off,
  output logic                   any_line
);
  logic [OFF_W-1:0] off_arr [LINES];

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_unpack
      assign off_arr[g] = offsets[g*OFF_W +: OFF_W];
    end
  endgenerate

  assign any_line = |sel;

  always_comb begin
    off = '0;
    // Walk downward so the lowest-numbered set line is applied last.
    for (int i = LINES - 1; i >= 0; i--) begin
      if (sel[i]) off = off_arr[i];
    end
    if (!any_line && alt_slot) off = off_arr[0];
  end
endmodule

// File: rtl/bvr_rom.sv
module bvr_rom #(
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0] idx,
  output logic [15:0]      word
);
  import bvr_pkg::*;
  assign word = rom_word(idx);
endmodule

// File: rtl/boot_vector_rom.sv
module boot_vector_rom #(
  parameter int ADDR_W = 18,
  parameter int LINES  = 4,
  parameter int OFF_W  = 8,
  parameter logic [15:0] PC_BASE = 16'o173000,
  parameter logic [15:0] PSW_VAL = 16'o000340
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_rd,
  input  logic                   bus_wr,
  input  logic [LINES-1:0]       start_sel,
  input  logic                   blind,
  input  logic [LINES*OFF_W-1:0] line_offset,
  input  logic                   ext_rom_en,
  output logic [15:0]            rsp_data,
  output logic                   rsp_ack
);
  import bvr_pkg::*;

  localparam int IDX_W = 8;

  logic             access;
  logic             pc_hit;
  logic             psw_hit;
  logic             alt_slot;
  logic [IDX_W-1:0] word_idx;
  logic [OFF_W-1:0] sel_off;
  logic             any_line;
  logic [15:0]      rom_q;
  logic [15:0]      pc_word;
  logic [15:0]      data_nxt;
  bvr_src_e         src;
  logic             unused_byte_bit;

  assign unused_byte_bit = bus_addr[0];

  bvr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (bus_addr[ADDR_W-1:1]),
    .rd       (bus_rd),
    .wr       (bus_wr),
    .blind    (blind),
    .ext_en   (ext_rom_en),
    .access   (access),
    .pc_hit   (pc_hit),
    .psw_hit  (psw_hit),
    .alt_slot (alt_slot),
    .word_idx (word_idx)
  );

  bvr_linesel #(.LINES(LINES), .OFF_W(OFF_W)) u_sel (
    .sel      (start_sel),
    .offsets  (line_offset),
    .alt_slot (alt_slot),
    .off      (sel_off),
    .any_line (any_line)
  );

  bvr_rom #(.IDX_W(IDX_W)) u_rom (
    .idx  (word_idx),
    .word (rom_q)
  );

  assign pc_word = start_word(PC_BASE, sel_off);

  always_comb begin
    if (!access)      src = SRC_NONE;
    else if (pc_hit)  src = SRC_PC;
    else if (psw_hit) src = SRC_PSW;
    else              src = SRC_ROM;
  end

  always_comb begin
    unique case (src)
      SRC_ROM: data_nxt = rom_q;
      SRC_PC:  data_nxt = pc_word;
      SRC_PSW: data_nxt = PSW_VAL;
      default: data_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_ack  <= 1'b0;
      rsp_data <= '0;
    end else begin
      rsp_ack  <= access;
      rsp_data <= data_nxt;
    end
  end
endmodule

// File: rtl/boot_vector_rom_chk.sv
module boot_vector_rom_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [17:0] bus_addr,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic        blind,
  input logic        ext_rom_en,
  input logic        pc_hit,
  input logic        psw_hit,
  input logic [15:0] rsp_data,
  input logic        rsp_ack
);
  // R10
  data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_ack |-> rsp_data == 16'd0);

  // R7
  blind_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |-> !$past(blind));

  // R8
  write_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |-> ($past(bus_rd) && !$past(bus_wr)));

  // R3
  ext_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ack && $past(bus_addr[8])) |-> $past(ext_rom_en));

  // R6
  psw_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(psw_hit) |-> (rsp_ack && rsp_data == 16'o000340));

  // R4
  pc_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pc_hit) |-> (rsp_ack && rsp_data[15:9] == 7'o173 && !rsp_data[0]));
endmodule

bind boot_vector_rom boot_vector_rom_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .blind      (blind),
  .ext_rom_en (ext_rom_en),
  .pc_hit     (pc_hit),
  .psw_hit    (psw_hit),
  .rsp_data   (rsp_data),
  .rsp_ack    (rsp_ack)
);

// File: tb/sim_boot_vector_rom.sv
`timescale 1ns/1ps
module sim_boot_vector_rom;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  start_sel = '0;
  logic        blind = 1'b0;
  logic [31:0] line_offset = {8'hC3, 8'h81, 8'h5A, 8'hA5};
  logic        ext_rom_en = 1'b0;
  logic [15:0] rsp_data;
  logic        rsp_ack;

  int vectors = 0;
  int errors  = 0;
  int unsigned lfsr = 32'h1ACE_B00C;

  always #2.5 clk = ~clk;

  boot_vector_rom u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .start_sel(start_sel), .blind(blind),
    .line_offset(line_offset), .ext_rom_en(ext_rom_en),
    .rsp_data(rsp_data), .rsp_ack(rsp_ack)
  );

  // Behavioural reference, written from the requirements.
  function automatic void model(input int a, input bit rd, input bit wr,
                                input int sel, input bit bl, input bit ext,
                                output bit e_ack, output int e_data);
    int w;
    int off;
    int line;
    e_ack = 0; e_data = 0;
    if (!rd || wr || bl) return;            // R7 R8
    if ((a / 512) != 'o773) return;          // R1
    w = a % 512;
    if (w >= 256 && !ext) return;            // R3
    e_ack = 1;
    line = -1;
    for (int k = 3; k >= 0; k--) if ((sel >> k) & 1) line = k;   // R9
    if (w == 'o24 || w == 'o25 || w == 'o224 || w == 'o225) begin
      if (line < 0 && w >= 'o200) line = 0;                        // R5
      off = (line < 0) ? 0 : ((line_offset >> (8 * line)) & 255);
      e_data = 'o173000 + off * 2;                                 // R4
    end else if (w == 'o26 || w == 'o27 || w == 'o226 || w == 'o227) begin
      e_data = 'o340;                                              // R6
    end else begin
      int i;
      i = w / 2;
      e_data = (i * 256 + (255 - i)) ^ 'hA55A;                     // R2
    end
  endfunction

  task automatic step(input int a, input bit rd, input bit wr, input int sel,
                      input bit bl, input bit ext, input string req);
    bit e_ack;
    int e_data;
    @(negedge clk);
    bus_addr = a[17:0]; bus_rd = rd; bus_wr = wr;
    start_sel = sel[3:0]; blind = bl; ext_rom_en = ext;
    model(a, rd, wr, sel, bl, ext, e_ack, e_data);
    @(negedge clk);
    vectors++;
    if (rsp_ack !== e_ack || rsp_data !== e_data[15:0]) begin
      errors++;
      $display("FAIL %s addr=%o ack=%b data=%o expected ack=%b data=%o",
               req, a, rsp_ack, rsp_data, e_ack, e_data[15:0]);
    end
  endtask

  task automatic idle_check(input string req);
    @(negedge clk);
    bus_rd = 0; bus_wr = 0;
    @(negedge clk);
    vectors++;
    if (rsp_ack !== 1'b0 || rsp_data !== 16'd0) begin
      errors++;
      $display("FAIL %s ack=%b data=%o expected ack=0 data=0", req, rsp_ack, rsp_data);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (rsp_ack !== 1'b0 || rsp_data !== 16'd0) begin
      errors++;
      $display("FAIL R10 reset ack=%b data=%o expected 0 0", rsp_ack, rsp_data);
    end
    rst_n = 1'b1;
    idle_check("R10 idle");

    // R1 R2 base ROM reads, odd byte address too
    step('o773000, 1, 0, 0, 0, 0, "R1 R2 word0");
    step('o773002, 1, 0, 0, 0, 0, "R2 word1");
    step('o773377, 1, 0, 0, 0, 0, "R1 odd byte last low word");
    step('o773122, 1, 0, 0, 0, 0, "R2 mid");
    // R1 outside window
    step('o772776, 1, 0, 0, 0, 1, "R1 below window");
    step('o774000, 1, 0, 0, 0, 1, "R1 above window");
    step('o000024, 1, 0, 1, 0, 1, "R1 far vector alias");
    // R3 extension gating
    step('o773400, 1, 0, 0, 0, 0, "R3 upper disabled");
    step('o773776, 1, 0, 0, 0, 0, "R3 upper last disabled");
    step('o773400, 1, 0, 0, 0, 1, "R3 upper enabled");
    step('o773776, 1, 0, 0, 0, 1, "R3 upper last enabled");
    step('o773424, 1, 0, 1, 0, 1, "R3 upper no vector");
    // R4 each line, both slots
    for (int n = 0; n < 4; n++) begin
      step('o773024, 1, 0, 1 << n, 0, 0, "R4 primary slot");
      step('o773224, 1, 0, 1 << n, 0, 0, "R4 alternate slot");
    end
    // R5 defaults
    step('o773024, 1, 0, 0, 0, 0, "R5 primary none plain base");
    step('o773224, 1, 0, 0, 0, 0, "R5 alternate none line1");
    step('o773225, 1, 0, 0, 0, 0, "R5 alternate odd byte");
    // R6 status word
    step('o773026, 1, 0, 4, 0, 0, "R6 primary psw");
    step('o773226, 1, 0, 0, 0, 1, "R6 alternate psw");
    // R9 priority
    step('o773024, 1, 0, 'b1100, 0, 0, "R9 lines 3+4");
    step('o773224, 1, 0, 'b1111, 0, 0, "R9 all lines");
    step('o773024, 1, 0, 'b1010, 0, 0, "R9 lines 2+4");
    // R7 blind
    step('o773024, 1, 0, 1, 1, 1, "R7 blind vector");
    step('o773000, 1, 0, 0, 1, 1, "R7 blind rom");
    step('o773000, 1, 0, 0, 0, 1, "R7 after blind");
    // R8 writes and no strobe
    step('o773000, 1, 1, 0, 0, 1, "R8 write");
    step('o773026, 0, 1, 0, 0, 1, "R8 write psw");
    step('o773000, 0, 0, 0, 0, 1, "R8 no strobe");
    idle_check("R10 after write");
    // Mixed pseudo-random traffic, compared every clock
    for (int k = 0; k < 600; k++) begin
      int a;
      lfsr = lfsr * 1664525 + 1013904223;
      a = (lfsr[0] ? 'o773000 : 'o772000) + ((lfsr >> 4) % 1024);
      step(a, lfsr[1] | lfsr[2], lfsr[3] & lfsr[9], (lfsr >> 12) & 15,
           lfsr[17] & lfsr[18], lfsr[21], "R1 R2 R3 R4 R5 R9 mixed");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule